// File: doc/BRIEF.md
# Programmable Baud Rate Generator Bank

This block holds four independent, programmable clock dividers. Each one produces single-cycle clock-enable pulses at sixteen times the serial bit rate. The serial receivers that consume these pulses oversample each bit sixteen times. Software writes one 32-bit configuration word per generator. The word carries a 12-bit reload value, a run bit and a select for an extra fixed divide-by-16 stage. Software computes the reload values itself. The block only counts.

A routing crossbar gives every serial channel its own generator select. Any generator can therefore clock any channel, and several channels can share one generator. Writing a configuration word restarts that generator's counters in the same cycle. A new rate is therefore in force at once, and the block never finishes the old period first. The base count rate is one step per system clock.

Top module: `baud_gen_bank`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every generator is stopped and every gen_tick and chan_tick output stays low until software writes a configuration word with the run bit set.
- R2: A configuration word carries the reload value D (0 to 4095) in bits 12:1, the divide-by-16 select in bit 0 and the run bit in bit 16; all other bits have no effect. With the run bit set and bit 0 clear, the generator's pulse is one cycle wide, its first pulse comes D+1 cycles after the write edge, and later pulses follow every D+1 cycles.
- R3: With D = 0, the run bit set and bit 0 clear, the pulse output is high on every cycle from the first cycle after the write edge onward.
- R4: With bit 0 set, a divide-by-16 stage runs ahead of the 12-bit counter: the first pulse comes 16*(D+1) cycles after the write edge, and the period is 16*(D+1).
- R5: With the run bit clear, the generator produces no pulses, and this holds even if the generator was running before the write.
- R6: A configuration write restarts both counters of that generator in the write cycle, so the first pulse at the new rate comes exactly one new period after the write edge, whatever phase the old count was in.
- R7: Each channel has a generator select that is written with route_we, route_chan and route_gen. The select resets to generator 0. Once the select has been written, the channel's chan_tick equals the gen_tick of the selected generator in the same cycle.
- R8: A configuration write to one generator leaves the count and period of every other generator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one count step per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_gen | input | 2 | Generator addressed by the write |
| cfg_wdata | input | 32 | Configuration word (run bit 16, reload 12:1, prescale select 0) |
| route_we | input | 1 | Routing select write strobe |
| route_chan | input | 2 | Channel whose select is written |
| route_gen | input | 2 | Generator to be routed to that channel |
| gen_tick | output | 4 | Clock-enable pulse of each generator |
| chan_tick | output | 4 | Clock-enable pulse delivered to each serial channel |

## Verification
The pulse output is a register, so the first pulse after a write shows one full period after the write edge. That period is D+1 cycles, or 16*(D+1) cycles when the divide-by-16 stage is selected. After that the pulses keep the same spacing. A routing change acts in the cycle after its write edge, and chan_tick follows gen_tick with no added delay. The bench counts clock edges from the write edge and samples on the falling edge. It then compares the first pulse position and the spacing between pulses with the values it computes from D and the prescale bit.

// File: rtl/baud_pkg.sv
// Shared constants and the decoded form of a generator configuration word.
// Assumes a 32-bit configuration word with fixed field positions.
package baud_pkg;
    localparam int DIV_W       = 12;   // reload counter width
    localparam int PRE_W       = 4;    // divide-by-16 prescaler width
    localparam int CFG_W       = 32;   // configuration word width
    localparam int CFG_PRE_BIT = 0;    // divide-by-16 select
    localparam int CFG_DIV_LSB = 1;    // reload value at bits 12:1
    localparam int CFG_RUN_BIT = 16;   // run bit

    typedef struct packed {
        logic             run;
        logic             pre;
        logic [DIV_W-1:0] div;
    } gen_cfg_t;

    // Extract the fields that matter from a raw configuration word.
    function automatic gen_cfg_t decode_cfg(input logic [CFG_W-1:0] word);
        gen_cfg_t c;
        c.run = word[CFG_RUN_BIT];
        c.pre = word[CFG_PRE_BIT];
        c.div = word[CFG_DIV_LSB +: DIV_W];
        return c;
    endfunction
endpackage

// File: rtl/baud_prescale.sv
// Optional divide-by-2**PRE_W stage in front of a reload counter.
// When use_pre is clear it passes one tick per cycle. When use_pre is set,
// it issues one tick each time its counter wraps. clear restarts the phase.
module baud_prescale #(
    parameter int PRE_W = 4,
    localparam logic [PRE_W-1:0] PRE_MAX = '1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic use_pre,
    output logic tick_o
);
    logic [PRE_W-1:0] cnt_q;

    // Phase counter; it is held at zero while stopped or being reloaded.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || !run) begin
            cnt_q <= '0;
        end else if (use_pre) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Tick to the reload counter: every cycle, or at a wrap of the prescaler.
    always_comb begin
        tick_o = run && !clear && (!use_pre || (cnt_q == PRE_MAX));
    end
endmodule

// File: rtl/baud_divider.sv
// Reload down-counter. It counts input ticks and emits a registered
// one-cycle pulse when it reaches zero, then reloads div_val.
// It assumes load comes together with the new div_val in the write cycle.
module baud_divider #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [DIV_W-1:0] div_val,
    input  logic             tick_in,
    output logic             pulse_o
);
    logic [DIV_W-1:0] cnt_q;
    logic             pulse_q;

    // Count, reload and pulse generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else if (load || !run) begin
            cnt_q   <= div_val;
            pulse_q <= 1'b0;
        end else if (tick_in) begin
            if (cnt_q == '0) begin
                cnt_q   <= div_val;
                pulse_q <= 1'b1;
            end else begin
                cnt_q   <= cnt_q - 1'b1;
                pulse_q <= 1'b0;
            end
        end else begin
            pulse_q <= 1'b0;
        end
    end

    assign pulse_o = pulse_q;
endmodule

// File: rtl/baud_xbar.sv
// Per-channel generator select with a combinational pulse mux.
// Every select resets to generator 0. It assumes route_gen < N_GEN.
module baud_xbar #(
    parameter int N_GEN  = 4,
    parameter int N_CHAN = 4,
    localparam int GEN_W  = (N_GEN  > 1) ? $clog2(N_GEN)  : 1,
    localparam int CHAN_W = (N_CHAN > 1) ? $clog2(N_CHAN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              route_we,
    input  logic [CHAN_W-1:0] route_chan,
    input  logic [GEN_W-1:0]  route_gen,
    input  logic [N_GEN-1:0]  gen_pulse,
    output logic [N_CHAN-1:0] chan_tick
);
    for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
        logic [GEN_W-1:0] sel_q;

        // Holds this channel's generator select.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_q <= '0;
            end else if (route_we && (route_chan == CHAN_W'(c))) begin
                sel_q <= route_gen;
            end
        end

        // Forwards the pulse of the selected generator.
        assign chan_tick[c] = gen_pulse[sel_q];
    end
endmodule

// File: rtl/baud_gen_bank.sv
// Bank of N_GEN baud generators with a routing crossbar to N_CHAN channels.
// A configuration write latches the word and restarts that generator's
// prescaler and counter in the same cycle. Count base is the system clock.
module baud_gen_bank
    import baud_pkg::*;
#(
    parameter int N_GEN  = 4,
    parameter int N_CHAN = 4,
    localparam int GEN_W  = (N_GEN  > 1) ? $clog2(N_GEN)  : 1,
    localparam int CHAN_W = (N_CHAN > 1) ? $clog2(N_CHAN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [GEN_W-1:0]  cfg_gen,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              route_we,
    input  logic [CHAN_W-1:0] route_chan,
    input  logic [GEN_W-1:0]  route_gen,
    output logic [N_GEN-1:0]  gen_tick,
    output logic [N_CHAN-1:0] chan_tick
);
    gen_cfg_t cfg_new;

    assign cfg_new = decode_cfg(cfg_wdata);

    for (genvar g = 0; g < N_GEN; g++) begin : g_gen
        gen_cfg_t         cfg_q;
        logic             load;
        logic             pre_tick;
        logic [DIV_W-1:0] div_sel;

        assign load = cfg_we && (cfg_gen == GEN_W'(g));

        // Configuration register of this generator.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q <= '0;
            end else if (load) begin
                cfg_q <= cfg_new;
            end
        end

        // The reload value comes from the incoming word during a write.
        assign div_sel = load ? cfg_new.div : cfg_q.div;

        baud_prescale #(.PRE_W(PRE_W)) u_pre (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (load),
            .run     (cfg_q.run),
            .use_pre (cfg_q.pre),
            .tick_o  (pre_tick)
        );

        baud_divider #(.DIV_W(DIV_W)) u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (load),
            .run     (cfg_q.run),
            .div_val (div_sel),
            .tick_in (pre_tick),
            .pulse_o (gen_tick[g])
        );
    end

    baud_xbar #(.N_GEN(N_GEN), .N_CHAN(N_CHAN)) u_xbar (
        .clk        (clk),
        .rst_n      (rst_n),
        .route_we   (route_we),
        .route_chan (route_chan),
        .route_gen  (route_gen),
        .gen_pulse  (gen_tick),
        .chan_tick  (chan_tick)
    );
endmodule

// File: rtl/baud_gen_bank_chk.sv
// Property checker for baud_gen_bank. It rebuilds run, fast-mode and route
// state from the write ports alone and checks the outputs against them.
module baud_gen_bank_chk
    import baud_pkg::*;
#(
    parameter int N_GEN  = 4,
    parameter int N_CHAN = 4,
    localparam int GEN_W  = (N_GEN  > 1) ? $clog2(N_GEN)  : 1,
    localparam int CHAN_W = (N_CHAN > 1) ? $clog2(N_CHAN) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [GEN_W-1:0]  cfg_gen,
    input logic [CFG_W-1:0]  cfg_wdata,
    input logic              route_we,
    input logic [CHAN_W-1:0] route_chan,
    input logic [GEN_W-1:0]  route_gen,
    input logic [N_GEN-1:0]  gen_tick,
    input logic [N_CHAN-1:0] chan_tick
);
    gen_cfg_t wr;
    assign wr = decode_cfg(cfg_wdata);

    for (genvar g = 0; g < N_GEN; g++) begin : g_gchk
        logic run_q, fast_q, wr_hit;
        assign wr_hit = cfg_we && (cfg_gen == GEN_W'(g));

        // Shadow of the run bit and of the every-cycle mode.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                run_q  <= 1'b0;
                fast_q <= 1'b0;
            end else if (wr_hit) begin
                run_q  <= wr.run;
                fast_q <= wr.run && !wr.pre && (wr.div == '0);
            end
        end

        // R5
        stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !run_q |-> !gen_tick[g]);

        // R2
        pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (gen_tick[g] && !fast_q) |=> !gen_tick[g]);

        // R3
        fast_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (gen_tick[g] && fast_q && !wr_hit) |=> gen_tick[g]);
    end

    for (genvar c = 0; c < N_CHAN; c++) begin : g_cchk
        logic [GEN_W-1:0] rt_q;

        // Shadow of this channel's route select.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rt_q <= '0;
            end else if (route_we && (route_chan == CHAN_W'(c))) begin
                rt_q <= route_gen;
            end
        end

        // R7
        route_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            chan_tick[c] == gen_tick[rt_q]);
    end
endmodule

bind baud_gen_bank baud_gen_bank_chk #(.N_GEN(N_GEN), .N_CHAN(N_CHAN)) u_chk (.*);

// File: tb/baud_gen_bank_tb.sv
`timescale 1ns/1ps
module baud_gen_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_gen = '0;
    logic [31:0] cfg_wdata = '0;
    logic        route_we = 1'b0;
    logic [1:0]  route_chan = '0;
    logic [1:0]  route_gen = '0;
    logic [3:0]  gen_tick;
    logic [3:0]  chan_tick;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    baud_gen_bank u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_gen(cfg_gen),
        .cfg_wdata(cfg_wdata), .route_we(route_we), .route_chan(route_chan),
        .route_gen(route_gen), .gen_tick(gen_tick), .chan_tick(chan_tick)
    );

    // Stimulus table: {generator, reload value D, prescale select}
    localparam int NV = 8;
    localparam int VEC [NV][3] = '{
        '{0, 0, 0}, '{1, 5, 0}, '{2, 4095, 0}, '{3, 2, 1},
        '{0, 0, 1}, '{1, 100, 0}, '{2, 1, 1}, '{3, 7, 0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input int g, input int d, input bit pre, input bit run);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_gen   = 2'(g);
        cfg_wdata = (32'(run) << 16) | (32'(d) << 1) | 32'(pre);
        @(posedge clk);
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic route_set(input int c, input int g);
        @(negedge clk);
        route_we   = 1'b1;
        route_chan = 2'(c);
        route_gen  = 2'(g);
        @(negedge clk);
        route_we   = 1'b0;
    endtask

    // Finds the first two pulse positions, counted in edges from the current point.
    task automatic watch(input int idx, input bit from_gen, input int limit,
                         output int t1, output int t2);
        t1 = -1;
        t2 = -1;
        for (int k = 1; k <= limit && t2 < 0; k++) begin
            bit v;
            @(negedge clk);
            v = from_gen ? gen_tick[idx] : chan_tick[idx];
            if (v) begin
                if (t1 < 0) t1 = k;
                else        t2 = k;
            end
        end
    endtask

    task automatic quiet_window(input string req, input int n);
        int hits = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (gen_tick != 0 || chan_tick != 0) hits++;
        end
        check(hits == 0, req, hits, 0);
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #750000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            report();
        end
    end

    initial begin
        int t1, t2, per, mism, cnt;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: nothing pulses after reset
        quiet_window("R1", 20);

        // R7: default route is generator 0 on every channel
        cfg_write(0, 3, 1'b0, 1'b1);
        mism = 0;
        cnt  = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (chan_tick != {4{gen_tick[0]}}) mism++;
            if (gen_tick[0]) cnt++;
        end
        check(mism == 0, "R7", mism, 0);
        check(cnt == 3, "R2", cnt, 3);

        // Table walk: R2 R3 R4 R7 (period and first-pulse offset per entry)
        for (int i = 0; i < NV; i++) begin
            per = VEC[i][2] ? 16 * (VEC[i][1] + 1) : VEC[i][1] + 1;
            route_set(i % 4, VEC[i][0]);
            cfg_write(VEC[i][0], VEC[i][1], VEC[i][2] != 0, 1'b1);
            watch(i % 4, 1'b0, 2 * per + 8, t1, t2);
            check(t1 == per, VEC[i][2] ? "R4 first" : "R2 first", t1, per);
            check(t2 - t1 == per, VEC[i][1] == 0 ? "R3 period" : "R2 period", t2 - t1, per);
        end

        // R5: a stopped generator stays silent, even after running
        cfg_write(1, 0, 1'b0, 1'b0);
        cnt = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (gen_tick[1]) cnt++;
        end
        check(cnt == 0, "R5", cnt, 0);

        // R6: a rewrite mid-period takes effect at once
        cfg_write(2, 1000, 1'b0, 1'b1);
        repeat (37) @(negedge clk);
        cfg_write(2, 3, 1'b0, 1'b1);
        watch(2, 1'b1, 20, t1, t2);
        check(t1 == 4, "R6 first", t1, 4);
        check(t2 - t1 == 4, "R6 period", t2 - t1, 4);

        // R8: writing generator 0 leaves generator 3 on its period
        cfg_write(3, 9, 1'b0, 1'b1);
        repeat (5) @(negedge clk);
        cfg_write(0, 2, 1'b1, 1'b1);
        watch(3, 1'b1, 30, t1, t2);
        check(t2 - t1 == 10, "R8", t2 - t1, 10);

        // R2: bits outside 16, 12:1 and 0 have no effect
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_gen   = 2'd1;
        cfg_wdata = 32'hFFFE_E000 | (32'd1 << 16) | (32'd4 << 1);
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        watch(1, 1'b1, 20, t1, t2);
        check(t1 == 5 && t2 - t1 == 5, "R2 spare bits", t1, 5);

        // R1: reset while running stops everything
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        quiet_window("R1 rerun", 30);

        done = 1'b1;
        report();
    end
endmodule